// File: doc/BRIEF.md
# Combining Merge Node for Sorted Request Streams

This block is one node of a synchronous merge tree. Two upstream producers each deliver packets in increasing address order. The node interleaves them into a single output stream that stays in increasing address order. Two real requests that reach the head of both queues with the same address leave as one request. That request carries the sum of both operands, and the left operand is handed out on a side port so that a later reply can be split again.

Three packet kinds travel through the node. Real requests carry an address and an operand. Ghost packets carry only an address, and promise that their side will send nothing below it. End-of-step packets close a step. Each input sits behind a small FIFO, because one side stalls while the other advances. The node acts only when both queue heads are known. An end-of-step head counts as an address above every other address, so the other side drains first, and a single end-of-step leaves the node only once both sides have supplied one.

Top module: `merge_combine_node`

## Requirements
- R1: When both heads are real requests with different addresses, the one with the smaller address is sent out and popped, and the other stays queued, so the output is in non-decreasing address order within a step.
- R2: When both heads are real requests with the same address, both are popped and one real request leaves with that address and an operand equal to the sum of both operands, taken modulo 2^DATA_W.
- R3: A combine raises split_valid for exactly one cycle, which is the first cycle the combined request is on the output, and split_data carries the left operand.
- R4: A ghost head with an address smaller than the other head leaves as a ghost (kind 1) with its address, and only that side is popped.
- R5: A real request and a ghost with the same address are both popped, and only the real request leaves, with its own operand and no split.
- R6: An end-of-step head (kind 2) acts as an address above every other address. The other side's packets are forwarded ahead of it, and one end-of-step leaves, popping both sides, only when both heads are end-of-step.
- R7: While either input queue is empty, no packet is sent out.
- R8: Each input queue holds 4 packets, and its ready output is low exactly while it holds 4.
- R9: While o_valid is high and o_ready is low, the output packet stays unchanged.
- R10: After reset, o_valid and split_valid are low and both input ready outputs are high.

Packet kind encoding: 0 real request, 1 ghost, 2 end-of-step; 3 is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_valid | input | 1 | Left packet offered |
| l_ready | output | 1 | Left queue has room |
| l_kind | input | 2 | Left packet kind |
| l_addr | input | ADDR_W | Left packet address |
| l_data | input | DATA_W | Left packet operand |
| r_valid | input | 1 | Right packet offered |
| r_ready | output | 1 | Right queue has room |
| r_kind | input | 2 | Right packet kind |
| r_addr | input | ADDR_W | Right packet address |
| r_data | input | DATA_W | Right packet operand |
| o_valid | output | 1 | Output packet present |
| o_ready | input | 1 | Downstream accepts output |
| o_kind | output | 2 | Output packet kind |
| o_addr | output | ADDR_W | Output packet address |
| o_data | output | DATA_W | Output packet operand |
| split_valid | output | 1 | One-cycle pulse on a combine |
| split_data | output | DATA_W | Left operand of the last combine |

## Verification
The hardest state to reach is a full input queue that also faces a stalled output. With one side empty the node never fires, so the bench first loads four packets into the left queue while the right queue stays empty. It checks that ready falls, and then holds o_ready low while a single right packet releases exactly one merge decision. The held output is then checked for stability, and the bench confirms that one freed slot raises ready again before the stream is drained and compared in order.

// File: rtl/merge_combine_node.sv
`timescale 1ns/1ps
module merge_combine_node #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_valid,
  output logic              l_ready,
  input  logic [1:0]        l_kind,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_data,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [1:0]        r_kind,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [1:0]        o_kind,
  output logic [ADDR_W-1:0] o_addr,
  output logic [DATA_W-1:0] o_data,
  output logic              split_valid,
  output logic [DATA_W-1:0] split_data
);
  localparam int PW = 2 + ADDR_W + DATA_W;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] K_REQ = 2'd0, K_GHOST = 2'd1, K_EOS = 2'd2;

  logic [1:0]    in_v, pop, hv, rdy;
  logic [PW-1:0] in_pkt [2];
  logic [PW-1:0] head   [2];

  assign in_v      = {r_valid, l_valid};
  assign in_pkt[0] = {l_kind, l_addr, l_data};
  assign in_pkt[1] = {r_kind, r_addr, r_data};
  assign l_ready   = rdy[0];
  assign r_ready   = rdy[1];

  for (genvar s = 0; s < 2; s++) begin : g_q
    logic [PW-1:0] mem [DEPTH];
    logic [IW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push;
    assign rdy[s]  = cnt != CW'(DEPTH);
    assign hv[s]   = cnt != '0;
    assign push    = in_v[s] && rdy[s];
    assign head[s] = mem[rp];

    always_ff @(posedge clk) if (push) mem[wp] <= in_pkt[s];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push)   wp <= (wp == IW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop[s]) rp <= (rp == IW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop[s]);
      end
    end
  end

  logic [1:0]        lk, rk, nk;
  logic [ADDR_W-1:0] la, ra, na;
  logic [DATA_W-1:0] ld, rd, nd;
  logic              adv, fire, nsplit;

  assign {lk, la, ld} = head[0];
  assign {rk, ra, rd} = head[1];
  assign adv  = !o_valid || o_ready;
  assign fire = adv && (&hv);

  always_comb begin
    pop = 2'b00; nk = K_GHOST; na = '0; nd = '0; nsplit = 1'b0;
    if (fire) begin
      if (lk == K_EOS && rk == K_EOS) begin
        pop = 2'b11; nk = K_EOS;
      end else if (lk == K_EOS || (rk != K_EOS && ra < la)) begin
        pop = 2'b10; nk = rk; na = ra; nd = rd;
      end else if (rk == K_EOS || la < ra) begin
        pop = 2'b01; nk = lk; na = la; nd = ld;
      end else begin
        pop = 2'b11; na = la;
        if (lk == K_REQ && rk == K_REQ) begin
          nk = K_REQ; nd = ld + rd; nsplit = 1'b1;
        end else if (lk == K_REQ) begin
          nk = K_REQ; nd = ld;
        end else if (rk == K_REQ) begin
          nk = K_REQ; nd = rd;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0; split_valid <= 1'b0;
      o_kind <= K_GHOST; o_addr <= '0; o_data <= '0; split_data <= '0;
    end else begin
      split_valid <= nsplit;
      if (nsplit) split_data <= ld;
      if (fire) begin
        o_valid <= 1'b1; o_kind <= nk; o_addr <= na; o_data <= nd;
      end else if (o_ready) begin
        o_valid <= 1'b0;
      end
    end
  end
endmodule

module merge_combine_node_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_valid,
  input logic              l_ready,
  input logic [1:0]        l_kind,
  input logic              r_valid,
  input logic              r_ready,
  input logic [1:0]        r_kind,
  input logic              o_valid,
  input logic              o_ready,
  input logic [1:0]        o_kind,
  input logic [ADDR_W-1:0] o_addr,
  input logic [DATA_W-1:0] o_data,
  input logic              split_valid,
  input logic [1:0]        pop
);
  localparam int CW = $clog2(DEPTH + 1) + 1;
  logic [CW-1:0]     occ_l, occ_r;
  logic [ADDR_W-1:0] last_a;
  logic              have_last, eos_l, eos_r, out_hs, out_eos;

  assign out_hs  = o_valid && o_ready;
  assign out_eos = out_hs && o_kind == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_l <= '0; occ_r <= '0; last_a <= '0; have_last <= 1'b0;
      eos_l <= 1'b0; eos_r <= 1'b0;
    end else begin
      occ_l <= occ_l + CW'(l_valid && l_ready) - CW'(pop[0]);
      occ_r <= occ_r + CW'(r_valid && r_ready) - CW'(pop[1]);
      if (out_eos) have_last <= 1'b0;
      else if (out_hs) begin have_last <= 1'b1; last_a <= o_addr; end
      if (l_valid && l_ready && l_kind == 2'd2) eos_l <= 1'b1;
      else if (out_eos) eos_l <= 1'b0;
      if (r_valid && r_ready && r_kind == 2'd2) eos_r <= 1'b1;
      else if (out_eos) eos_r <= 1'b0;
    end
  end

  AST_SORTED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && o_kind != 2'd2 && have_last) |-> o_addr >= last_a); // R1
  AST_SPLIT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    split_valid |-> (o_valid && o_kind == 2'd0)); // R3
  AST_EOS_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
    out_eos |-> (eos_l && eos_r)); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop != 2'b00) |-> (occ_l != '0 && occ_r != '0)); // R7
  AST_LEFT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !l_ready == (occ_l == CW'(DEPTH))); // R8
  AST_RIGHT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !r_ready == (occ_r == CW'(DEPTH))); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_kind) && $stable(o_addr) && $stable(o_data))); // R9
endmodule

bind merge_combine_node merge_combine_node_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_valid(l_valid), .l_ready(l_ready), .l_kind(l_kind),
  .r_valid(r_valid), .r_ready(r_ready), .r_kind(r_kind),
  .o_valid(o_valid), .o_ready(o_ready), .o_kind(o_kind),
  .o_addr(o_addr), .o_data(o_data), .split_valid(split_valid), .pop(pop)
);

// File: tb/test_merge_combine_node.sv
`timescale 1ns/1ps
module test_merge_combine_node;
  localparam int AW = 16, DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic l_valid = 1'b0, r_valid = 1'b0, o_ready = 1'b1;
  logic [1:0] l_kind = '0, r_kind = '0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_data = '0, r_data = '0;
  logic l_ready, r_ready, o_valid, split_valid;
  logic [1:0] o_kind;
  logic [AW-1:0] o_addr;
  logic [DW-1:0] o_data, split_data;

  always #2.5 clk = ~clk;

  merge_combine_node #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) i_merge_combine_node (
    .clk(clk), .rst_n(rst_n),
    .l_valid(l_valid), .l_ready(l_ready), .l_kind(l_kind), .l_addr(l_addr), .l_data(l_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_kind(r_kind), .r_addr(r_addr), .r_data(r_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_kind(o_kind), .o_addr(o_addr), .o_data(o_data),
    .split_valid(split_valid), .split_data(split_data));

  int checks = 0, fails = 0, n_rec = 0, n_sp = 0;
  logic [1:0]    rk [32];
  logic [AW-1:0] ra [32];
  logic [DW-1:0] rd [32];
  logic [DW-1:0] sp [32];

  always @(negedge clk) begin
    if (rst_n && o_valid && o_ready && n_rec < 32) begin
      rk[n_rec] = o_kind; ra[n_rec] = o_addr; rd[n_rec] = o_data; n_rec++;
    end
    if (rst_n && split_valid && n_sp < 32) begin
      sp[n_sp] = split_data; n_sp++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_rec(input int i, input logic [1:0] k, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string tag);
    if (i >= n_rec) chk(1'b0, tag, 64'(n_rec), 64'(i + 1));
    else chk(rk[i] == k && ra[i] == a && (k != 2'd0 || rd[i] == d), tag,
             {30'd0, rk[i], ra[i], rd[i]}, {30'd0, k, a, d});
  endtask

  task automatic push(input bit side, input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    if (!side) begin l_valid = 1'b1; l_kind = k; l_addr = a; l_data = d; end
    else       begin r_valid = 1'b1; r_kind = k; r_addr = a; r_data = d; end
    do @(negedge clk); while (side ? !r_ready : !l_ready);
    @(posedge clk); #1;
    if (!side) l_valid = 1'b0; else r_valid = 1'b0;
  endtask

  task automatic clear_log();
    @(posedge clk); #1; n_rec = 0; n_sp = 0;
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!o_valid && !split_valid, "R10 outputs idle after reset", {o_valid, split_valid}, 0);
    chk(l_ready && r_ready, "R10 inputs ready after reset", {l_ready, r_ready}, 2'b11);
  endtask

  task automatic t_sort();
    clear_log();
    push(0, 2'd0, 16'd3, 16'h11); push(0, 2'd0, 16'd9, 16'h22); push(0, 2'd2, 0, 0);
    settle();
    chk(n_rec == 0 && !o_valid, "R7 no output while right empty", 64'(n_rec), 0);
    push(1, 2'd0, 16'd5, 16'h33); push(1, 2'd0, 16'd12, 16'h44); push(1, 2'd2, 0, 0);
    settle();
    chk(n_rec == 5, "R1 record count", 64'(n_rec), 5);
    expect_rec(0, 2'd0, 16'd3, 16'h11, "R1 first smallest");
    expect_rec(1, 2'd0, 16'd5, 16'h33, "R1 right waits then goes");
    expect_rec(2, 2'd0, 16'd9, 16'h22, "R1 third");
    expect_rec(3, 2'd0, 16'd12, 16'h44, "R6 right drains before eos");
    expect_rec(4, 2'd2, 16'd0, 16'h0, "R6 single eos");
    chk(n_sp == 0, "R1 no split", 64'(n_sp), 0);
  endtask

  task automatic t_combine();
    clear_log();
    push(0, 2'd0, 16'd7, 16'hFFF0); push(0, 2'd2, 0, 0);
    push(1, 2'd0, 16'd7, 16'h0020); push(1, 2'd2, 0, 0);
    settle();
    chk(n_rec == 2, "R2 one combined request plus eos", 64'(n_rec), 2);
    expect_rec(0, 2'd0, 16'd7, 16'h0010, "R2 sum wraps");
    expect_rec(1, 2'd2, 16'd0, 16'h0, "R6 eos after combine");
    chk(n_sp == 1, "R3 one split pulse", 64'(n_sp), 1);
    chk(n_sp > 0 && sp[0] == 16'hFFF0, "R3 split carries left operand", sp[0], 16'hFFF0);
  endtask

  task automatic t_ghost();
    clear_log();
    push(0, 2'd1, 16'd4, 16'h0); push(0, 2'd0, 16'd10, 16'h0001); push(0, 2'd2, 0, 0);
    push(1, 2'd0, 16'd6, 16'h0002); push(1, 2'd1, 16'd10, 16'h0); push(1, 2'd2, 0, 0);
    settle();
    chk(n_rec == 4, "R4 record count", 64'(n_rec), 4);
    expect_rec(0, 2'd1, 16'd4, 16'h0, "R4 smaller ghost forwarded");
    expect_rec(1, 2'd0, 16'd6, 16'h0002, "R4 other side kept");
    expect_rec(2, 2'd0, 16'd10, 16'h0001, "R5 tie keeps real request");
    expect_rec(3, 2'd2, 16'd0, 16'h0, "R5 ghost left no packet");
    chk(n_sp == 0, "R5 no split on ghost tie", 64'(n_sp), 0);
  endtask

  task automatic t_eos_wait();
    clear_log();
    push(0, 2'd2, 0, 0);
    push(1, 2'd0, 16'd2, 16'h5); push(1, 2'd0, 16'd8, 16'h6);
    settle();
    chk(n_rec == 2, "R6 eos held until both sides", 64'(n_rec), 2);
    expect_rec(0, 2'd0, 16'd2, 16'h5, "R6 first past eos");
    expect_rec(1, 2'd0, 16'd8, 16'h6, "R6 second past eos");
    push(1, 2'd2, 0, 0);
    settle();
    chk(n_rec == 3, "R6 eos after both", 64'(n_rec), 3);
    expect_rec(2, 2'd2, 16'd0, 16'h0, "R6 eos kind");
  endtask

  task automatic t_full();
    clear_log();
    @(posedge clk); #1; o_ready = 1'b0;
    for (int i = 1; i <= 4; i++) push(0, 2'd0, 16'(i), 16'(i));
    @(negedge clk);
    chk(!l_ready, "R8 left ready low at 4", l_ready, 0);
    chk(r_ready, "R8 right ready high when empty", r_ready, 1);
    push(1, 2'd0, 16'd20, 16'h99);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(o_valid && o_kind == 2'd0 && o_addr == 16'd1, "R9 output held",
        {o_valid, o_kind, o_addr}, {1'b1, 2'd0, 16'd1});
    chk(l_ready, "R8 ready back after one pop", l_ready, 1);
    @(posedge clk); #1; o_ready = 1'b1;
    push(0, 2'd2, 0, 0); push(1, 2'd2, 0, 0);
    settle();
    chk(n_rec == 6, "R9 nothing lost under stall", 64'(n_rec), 6);
    for (int i = 0; i < 4; i++) expect_rec(i, 2'd0, 16'(i + 1), 16'(i + 1), "R8 queued order");
    expect_rec(4, 2'd0, 16'd20, 16'h99, "R1 larger last");
    expect_rec(5, 2'd2, 16'd0, 16'h0, "R6 final eos");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sort();
    t_combine();
    t_ghost();
    t_eos_wait();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule